// File: doc/BRIEF.md
# Single-Stage Parallel Word Sorter

This block sorts N unsigned words of width W in one logic stage. It does not pass the words through a chain of compare-exchange cells. A first layer evaluates every pairwise comparison at the same time. A second layer works out, from those comparison bits alone, the rank of each input. Each output port is then an AND-OR multiplexer over the raw input words, steered by that rank decode. The wiring from inputs to outputs never depends on the data values. The block is therefore data-oblivious and has the same depth for every input pattern.

When two inputs are equal, the tie is broken by input position, so every input word lands on exactly one output. Equal values are never duplicated or lost, and this includes the case where all inputs are equal. A parameter selects a registered output, which adds one cycle of latency and has a synchronous clear. With the register off, the output is purely combinational. N may be 2, 3 or 4.

Top module: `n_sorter`

## Requirements
- R1: Output word k sits at `out_flat[k*W +: W]`. Word 0 holds the smallest value, and each word k is less than or equal to word k+1 (unsigned).
- R2: The outputs form the same multiset as the inputs. No value is duplicated or dropped when some inputs are equal.
- R3: When all inputs carry the same value, every output word equals that value.
- R4: A 2-word instance sorts all four 0-1 input vectors correctly. The equal ordering is reached by both 00 and 11.
- R5: For N=4 and N=3, all 2^N input vectors whose words are each 0 or 1 produce correctly sorted outputs.
- R6: Each output word selects exactly one input word. Ties between inputs i and j (i > j) are decided by greater-or-equal from the higher index and strictly-greater from the lower one.
- R7: With `REG_OUT=1`, the sorted result for the inputs present at a rising clock edge appears after that edge, and the output keeps its old value until that edge.
- R8: With `REG_OUT=1`, a synchronous reset (`rst` high at a rising edge) sets every output word to zero.
- R9: With `REG_OUT=0`, the outputs follow the inputs combinationally, with no clock edge needed.
- R10: On random W-bit inputs that include many repeated values, the outputs match a reference sort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| in_flat | input | N*W | N unsigned input words, word i at bits [i*W +: W] |
| out_flat | output | N*W | N sorted words, ascending from word 0 |

## Verification
The assertions take for granted that the inputs are driven to known values from time zero. They also take for granted that the inputs change only away from the rising edge, so a registered output always reflects a single, settled input set. The stimulus meets both conditions: it sets every input to zero before the first edge and changes the inputs only on falling edges. Ties are pushed hard, with exhaustive 0-1 vectors, all-equal words and random words drawn from a narrow range. This makes the tie-breaking select logic reach every rank collision.

// File: rtl/sorter_pkg.sv
package sorter_pkg;

    localparam int unsigned MIN_WORDS = 2;
    localparam int unsigned MAX_WORDS = 4;

    // Direction of a comparison when the two words are equal:
    // the higher index wins a tie, so it uses greater-or-equal.
    function automatic bit tie_wins(input int unsigned i, input int unsigned j);
        return i > j;
    endfunction

endpackage

// File: rtl/sort_cmp_matrix.sv
module sort_cmp_matrix #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 8
) (
    input  logic [N*W-1:0] in_flat,
    output logic [N*N-1:0] beats
);
    import sorter_pkg::*;

    // beats[i*N+j] is high when word i ranks above word j.
    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            if (i == j) begin : g_diag
                assign beats[i*N+j] = 1'b0;
            end else if (tie_wins(i, j)) begin : g_ge
                assign beats[i*N+j] = in_flat[i*W +: W] >= in_flat[j*W +: W];
            end else begin : g_gt
                assign beats[i*N+j] = in_flat[i*W +: W] >  in_flat[j*W +: W];
            end
        end
    end

endmodule

// File: rtl/sort_rank.sv
module sort_rank #(
    parameter int unsigned N = 4
) (
    input  logic [N*N-1:0] beats,
    output logic [N*N-1:0] sel
);
    localparam int unsigned RW = $clog2(N) + 1;

    logic [RW-1:0] rank_d [N];

    // Rank of word i = number of words it beats; sel[k*N+i] picks word i for output k.
    always_comb begin
        sel = '0;
        for (int i = 0; i < N; i++) begin
            rank_d[i] = '0;
            for (int j = 0; j < N; j++) begin
                rank_d[i] = rank_d[i] + RW'(beats[i*N+j]);
            end
            for (int k = 0; k < N; k++) begin
                if (rank_d[i] == RW'(k)) begin
                    sel[k*N+i] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sort_out_mux.sv
module sort_out_mux #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N*W-1:0] in_flat,
    input  logic [N*N-1:0] sel,
    output logic [N*W-1:0] out_flat
);

    for (genvar k = 0; k < N; k++) begin : g_port
        logic [N-1:0] row;
        assign row = sel[k*N +: N];

        always_comb begin
            out_flat[k*W +: W] = '0;
            for (int i = 0; i < N; i++) begin
                out_flat[k*W +: W] = out_flat[k*W +: W] | ({W{row[i]}} & in_flat[i*W +: W]);
            end
        end

        // R6
        one_source_chk: assert property (@(posedge clk) disable iff (rst)
            $countones(row) == 1);
    end

endmodule

// File: rtl/n_sorter.sv
module n_sorter #(
    parameter int unsigned N       = 4,
    parameter int unsigned W       = 8,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N*W-1:0] in_flat,
    output logic [N*W-1:0] out_flat
);
    import sorter_pkg::*;

    localparam int unsigned SW = W + $clog2(N) + 1;

    if (N < MIN_WORDS || N > MAX_WORDS) begin : g_bad_n
        $error("n_sorter: N out of range");
    end

    logic [N*N-1:0] beats;
    logic [N*N-1:0] sel;
    logic [N*W-1:0] sorted;

    sort_cmp_matrix #(.N(N), .W(W)) u_cmp (
        .in_flat (in_flat),
        .beats   (beats)
    );

    sort_rank #(.N(N)) u_rank (
        .beats (beats),
        .sel   (sel)
    );

    sort_out_mux #(.N(N), .W(W)) u_mux (
        .clk      (clk),
        .rst      (rst),
        .in_flat  (in_flat),
        .sel      (sel),
        .out_flat (sorted)
    );

    if (REG_OUT) begin : g_reg
        typedef struct packed {
            logic [N*W-1:0] data;
        } out_st_t;

        out_st_t st_d, st_q;

        always_comb begin
            st_d      = st_q;
            st_d.data = sorted;
            if (rst) begin
                st_d = '0;
            end
        end

        always_ff @(posedge clk) begin
            st_q <= st_d;
        end

        assign out_flat = st_q.data;

        // R8
        reset_clear_chk: assert property (@(posedge clk)
            rst |=> out_flat == '0);

        // R7
        one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $stable(in_flat)) |=> $stable(out_flat));
    end else begin : g_comb
        assign out_flat = sorted;
    end

    // Sum of words, used only by the conservation check below.
    function automatic logic [SW-1:0] word_sum(input logic [N*W-1:0] v);
        logic [SW-1:0] s;
        s = '0;
        for (int i = 0; i < N; i++) begin
            s = s + SW'(v[i*W +: W]);
        end
        return s;
    endfunction

    logic [SW-1:0] in_sum, out_sum;
    assign in_sum  = word_sum(in_flat);
    assign out_sum = word_sum(out_flat);

    if (REG_OUT) begin : g_sum_reg
        // R2
        conserve_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> out_sum == $past(in_sum));
    end else begin : g_sum_comb
        // R2
        conserve_chk: assert property (@(posedge clk) disable iff (rst)
            out_sum == in_sum);
    end

    for (genvar k = 0; k + 1 < N; k++) begin : g_order
        // R1
        ascending_chk: assert property (@(posedge clk) disable iff (rst)
            out_flat[k*W +: W] <= out_flat[(k+1)*W +: W]);
    end

endmodule

// File: tb/tb_n_sorter.sv
module tb_n_sorter;
    localparam int W  = 8;
    localparam int W2 = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [4*W-1:0]  din4 = '0;
    logic [3*W-1:0]  din3 = '0;
    logic [2*W2-1:0] din2 = '0;
    logic [4*W-1:0]  out_r, out_c;
    logic [3*W-1:0]  out3;
    logic [2*W2-1:0] out2;

    n_sorter #(.N(4), .W(W),  .REG_OUT(1'b1)) dut   (.clk(clk), .rst(rst), .in_flat(din4), .out_flat(out_r));
    n_sorter #(.N(4), .W(W),  .REG_OUT(1'b0)) dut_c (.clk(clk), .rst(rst), .in_flat(din4), .out_flat(out_c));
    n_sorter #(.N(3), .W(W),  .REG_OUT(1'b0)) dut3  (.clk(clk), .rst(rst), .in_flat(din3), .out_flat(out3));
    n_sorter #(.N(2), .W(W2), .REG_OUT(1'b0)) dut2  (.clk(clk), .rst(rst), .in_flat(din2), .out_flat(out2));

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    logic [4*W-1:0] last_exp = '0;

    typedef struct {
        logic [4*W-1:0] exp;
        int             due;
        string          tag;
    } item_t;
    item_t sb[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_sort(input logic [31:0] v, input int n, input int w);
        int a[4];
        int t;
        logic [31:0] r;
        for (int i = 0; i < n; i++) a[i] = int'((v >> (i*w)) & ((32'd1 << w) - 1));
        for (int i = 1; i < n; i++) begin
            for (int j = i; j > 0 && a[j-1] > a[j]; j--) begin
                t = a[j]; a[j] = a[j-1]; a[j-1] = t;
            end
        end
        r = '0;
        for (int i = 0; i < n; i++) r = r | (32'(a[i]) << (i*w));
        return r;
    endfunction

    // Monitor: pops the item due in this cycle and compares it with the registered output.
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            check({sb[0].tag, " R7 reg"}, out_r, sb[0].exp);
            sb.pop_front();
        end
    end

    // Driver: called on a falling edge, returns on the next falling edge.
    task automatic apply(input logic [31:0] v4, input logic [23:0] v3, input logic [7:0] v2, input string tag);
        item_t it;
        din4 = v4;
        din3 = v3;
        din2 = v2;
        it.exp = ref_sort(v4, 4, W);
        it.due = cyc + 1;
        it.tag = tag;
        sb.push_back(it);
        #1;
        check({tag, " R9 comb N=4"}, out_c, ref_sort(v4, 4, W));
        check({tag, " N=3"}, {8'h0, out3}, ref_sort({8'h0, v3}, 3, W));
        check({tag, " N=2"}, {24'h0, out2}, ref_sort({24'h0, v2}, 2, W2));
        check("R7 holds before edge", out_r, last_exp);
        last_exp = it.exp;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v4;
        logic [23:0] v3;
        logic [7:0]  v2;
        repeat (3) @(negedge clk);
        check("R8 reset state", out_r, '0);
        rst = 1'b0;

        // R4: 2-word 0-1 vectors; R5/R6: exhaustive 0-1 for N=4 and N=3
        for (int v = 0; v < 16; v++) begin
            v4 = '0; v3 = '0; v2 = '0;
            for (int i = 0; i < 4; i++) v4[i*W] = v[i];
            for (int i = 0; i < 3; i++) v3[i*W] = v[i];
            for (int i = 0; i < 2; i++) v2[i*W2] = v[i];
            apply(v4, v3, v2, "R4/R5/R6 zero-one");
        end

        // R3: all inputs equal
        apply({4{8'h00}}, {3{8'h00}}, {2{4'h0}}, "R3 all-equal 00");
        apply({4{8'hFF}}, {3{8'hFF}}, {2{4'hF}}, "R3 all-equal FF");
        apply({4{8'h5A}}, {3{8'h5A}}, {2{4'h5}}, "R3 all-equal 5A");
        check("R3 every word equal", out_c, {4{8'h5A}});

        // R1/R2/R10: random with many duplicates
        for (int n = 0; n < 300; n++) begin
            for (int i = 0; i < 4; i++)
                v4[i*W +: W] = (n % 2 == 0) ? 8'($urandom_range(0, 3)) : 8'($urandom);
            for (int i = 0; i < 3; i++)
                v3[i*W +: W] = (n % 3 == 0) ? 8'($urandom_range(250, 255)) : 8'($urandom_range(0, 2));
            v2 = 8'($urandom_range(0, 255));
            apply(v4, v3, v2, "R1/R2/R10 random");
        end

        // R8: reset in mid-run clears the register
        apply(32'h0A03_FF11, 24'h01_0203, 8'h21, "R10 before reset");
        rst = 1'b1;
        sb.delete();
        @(negedge clk);
        check("R8 mid-run reset", out_r, '0);
        rst = 1'b0;
        last_exp = '0;
        apply(32'h0102_0304, 24'h03_0201, 8'h12, "R1 after reset");
        repeat (2) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule